// File: doc/BRIEF.md
# Zero-Stuffing Upsampler Front End

This block sits in front of an interpolation filter and turns a stream of input samples into a stream of twice the rate with zeros inserted. A small counter runs continuously over a frame of sixteen clocks. In the first half of each frame, a sample register passes the incoming sample on toward the filter. In the second half, the top bit of the counter clears that register, so the filter sees zeros.

The upstream source watches a frame strobe. The strobe is high in the cycle where the counter reads zero, and the source uses it to line up the next sample with the pass half of the frame. The register is updated at every clock edge. Whether it loads or clears is decided by the count the edge moves into. As a result, the output during a pass count equals the input as it stood in the cycle before.

Top module: `zstuff_front`

## Requirements
- R1: While reset is high, and in the first cycle after it is released, the output is zero, and that first cycle is count 0, so the frame strobe is high in it.
- R2: The frame counter goes up by one at every clock edge outside reset and wraps from 15 to 0. Seen at the ports, the frame strobe repeats exactly every 16 clocks.
- R3: During counts 0 to 7 (most significant count bit 0), the output equals the value the sample input held in the previous clock cycle.
- R4: During counts 8 to 15 (most significant count bit 1), the output is zero whatever value the sample input carries.
- R5: The frame strobe is high only in the one cycle of each frame where the count is 0, and low in the other fifteen.
- R6: A reset applied at any count in the middle of a frame restarts the frame: the count returns to 0 and the pass and zero halves follow from there.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| smp_in | input | 8 | Sample from the upstream source |
| smp_out | output | 8 | Sample or inserted zero toward the filter |
| frame_start | output | 1 | High in the cycle where the frame count is 0 |

## Verification
The bench follows the frame count with its own model and checks the output on every clock. It looks hardest at the edge between count 7 and count 8, and at the wrap from 15 back to 0. A design that took the clear from the current count, instead of the next one, would let one extra sample through at count 8 and would zero count 0. Nonzero inputs are driven during the zero half, so a clear that leaks or is tied to the wrong counter bit shows up as a nonzero output. A reset applied in the middle of a frame catches a counter that keeps its old phase: the strobe and the halves would then appear at the wrong cycles.

// File: rtl/zstuff_front.sv
module zstuff_front #(
  parameter int DW = 8,
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] smp_in,
  output logic [DW-1:0] smp_out,
  output logic          frame_start
);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_nx;
  logic [DW-1:0] hold_q;

  assign cnt_nx = cnt_q + CW'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      hold_q <= '0;
    end else begin
      cnt_q  <= cnt_nx;
      hold_q <= cnt_nx[CW-1] ? '0 : smp_in;
    end
  end

  assign smp_out     = hold_q;
  assign frame_start = (cnt_q == '0);

endmodule

// File: rtl/zstuff_front_chk.sv
module zstuff_front_chk #(
  parameter int DW = 8,
  parameter int CW = 4
) (
  input logic          clk,
  input logic          rst,
  input logic [DW-1:0] smp_in,
  input logic [DW-1:0] smp_out,
  input logic          frame_start,
  input logic [CW-1:0] cnt
);

  logic last_cnt;
  logic mid_last;
  assign last_cnt = &cnt;
  assign mid_last = (cnt == {1'b0, {(CW-1){1'b1}}});

  a_r2_count_step: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> cnt == $past(cnt) + CW'(1));

  a_r3_pass_half: assert property (@(posedge clk) disable iff (rst)
    (last_cnt || (!cnt[CW-1] && !mid_last)) |=> smp_out == $past(smp_in));

  a_r4_zero_half: assert property (@(posedge clk) disable iff (rst)
    cnt[CW-1] |-> smp_out == '0);

  a_r5_strobe_single: assert property (@(posedge clk) disable iff (rst)
    frame_start |=> !frame_start);

  a_r5_strobe_after_wrap: assert property (@(posedge clk) disable iff (rst)
    last_cnt |=> frame_start);

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (smp_out == '0 && cnt == '0));

endmodule

bind zstuff_front zstuff_front_chk #(.DW(DW), .CW(CW)) u_chk (
  .clk(clk), .rst(rst), .smp_in(smp_in), .smp_out(smp_out),
  .frame_start(frame_start), .cnt(cnt_q)
);

// File: tb/sim_zstuff_front.sv
module sim_zstuff_front;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] smp_in = 8'h00;
  logic [7:0] smp_out;
  logic       frame_start;

  int total = 0;
  int bad = 0;
  logic [3:0] mcnt = 4'd0;
  logic [31:0] lfsr = 32'h1234_5678;

  always #2 clk = ~clk;

  zstuff_front u0 (
    .clk(clk), .rst(rst), .smp_in(smp_in),
    .smp_out(smp_out), .frame_start(frame_start)
  );

  task automatic chk8(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s cnt=%0d actual=%h expected=%h", req, mcnt, act, exp);
    end
  endtask

  task automatic tick(input logic [7:0] v);
    logic [7:0] e;
    smp_in = v;
    @(negedge clk);
    mcnt = mcnt + 4'd1;
    e = mcnt[3] ? 8'h00 : v;
    chk8(mcnt[3] ? "R4" : "R3", smp_out, e);
    chk8((mcnt == 4'd0) ? "R2" : "R5", {7'd0, frame_start}, {7'd0, mcnt == 4'd0});
  endtask

  task automatic do_reset(input string req);
    rst = 1'b1;
    smp_in = 8'hA5;
    @(negedge clk);
    chk8("R1", smp_out, 8'h00);
    @(negedge clk);
    rst = 1'b0;
    mcnt = 4'd0;
    chk8(req, smp_out, 8'h00);
    chk8(req, {7'd0, frame_start}, 8'h01);
  endtask

  task automatic t_random_frames();
    for (int i = 0; i < 48; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      tick(lfsr[7:0] | 8'h01);
    end
  endtask

  task automatic t_held_samples();
    logic [7:0] s [3] = '{8'hFF, 8'h80, 8'h01};
    for (int f = 0; f < 3; f++)
      for (int k = 0; k < 16; k++)
        tick((k < 8) ? s[f] : 8'h7E);
  endtask

  task automatic t_half_edges();
    while (mcnt != 4'd6) tick(8'h11);
    tick(8'h3C);
    chk8("R3", smp_out, 8'h3C);
    tick(8'hC3);
    chk8("R4", smp_out, 8'h00);
    while (mcnt != 4'd14) tick(8'hEE);
    tick(8'h5A);
    chk8("R2", {7'd0, frame_start}, 8'h00);
    tick(8'h66);
    chk8("R2", {7'd0, frame_start}, 8'h01);
    chk8("R3", smp_out, 8'h66);
  endtask

  task automatic t_mid_reset();
    while (mcnt != 4'd5) tick(8'h42);
    do_reset("R6");
    for (int i = 0; i < 20; i++) tick(8'(8'h20 + i));
    while (mcnt != 4'd11) tick(8'h99);
    do_reset("R6");
    for (int i = 0; i < 16; i++) tick(8'h5B);
  endtask

  initial begin
    #400000;
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset("R1");
    t_random_frames();
    t_held_samples();
    t_half_edges();
    t_mid_reset();
    t_random_frames();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule